// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block holds the hazard control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Each instruction passes through every stage. Registers are read in decode and written in write-back, so the only hazard it has to handle is a read that follows a write. The controller compares the source register numbers of the instruction in decode with the destination numbers of the two instructions ahead of it. It then picks, for each ALU operand, whether that operand comes from the register file or is bypassed from one of the two later pipeline registers. It also decides when the front of the pipe must freeze for a cycle.

The operand selects are worked out one cycle early, during decode, and registered alongside the decode-to-execute pipeline register. The ALU multiplexers therefore see a settled select at the start of execute. A load followed at once by a consumer of its result costs one frozen cycle. During that cycle `stall` holds the program counter and the fetch/decode register, and `bubble` turns the decode-to-execute register into a no-op with its write-enable and memory flags cleared. When `SHARED_PORT` is set, instruction fetch and data access share one memory port. Any load or store in the memory stage then freezes fetch in the same way. Every pin is a plain control or status level. The block sits inside the pipeline's own timing, so it has no valid/ready flow and applies no back-pressure.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: If the instruction one ahead (now in execute) writes a used source register other than register 0, that operand's select is 2'b10 (EX/MEM bypass) in the following cycle, once the consumer has reached execute.
- R2: If only the instruction two ahead (now in memory) writes a used source register other than register 0, that operand's select is 2'b01 (MEM/WB bypass) in the following cycle.
- R3: When both later stages match the same source, the select is 2'b10, because the nearer result is the younger one.
- R4: The select is 2'b00 (register file) when the matching destination is register 0, when the producer's write-enable is low, or when the operand is not used.
- R5: A load in execute whose destination is a used source of the instruction in decode raises `stall` and `bubble` for exactly one cycle. After that cycle the consumer reaches execute with select 2'b01.
- R6: `stall` and `bubble` are always asserted together. The cycle after a stall, both selects are 2'b00, because execute then holds the inserted no-op.
- R7: With `SHARED_PORT` = 1, a load or store in the memory stage (`mem_acc` high) raises `stall` and `bubble`. With `SHARED_PORT` = 0, `mem_acc` has no effect on `stall`.
- R8: While reset is active, both selects read 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_rs1 | input | REG_BITS | First source register of the instruction in decode |
| id_rs2 | input | REG_BITS | Second source register of the instruction in decode |
| id_use1 | input | 1 | Decode instruction reads its first source |
| id_use2 | input | 1 | Decode instruction reads its second source |
| ex_rd | input | REG_BITS | Destination of the instruction in execute |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_BITS | Destination of the instruction in memory |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_acc | input | 1 | Memory-stage instruction accesses data memory |
| fwd_a | output | 2 | Select for ALU operand A: 00 file, 10 EX/MEM, 01 MEM/WB |
| fwd_b | output | 2 | Select for ALU operand B, same encoding |
| stall | output | 1 | Hold PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode-to-execute register |

## Verification
The assertions take for granted that the execute and memory inputs describe the instructions that will sit in EX/MEM and MEM/WB one cycle later. In other words, the surrounding pipeline really does advance by one stage each cycle and puts a cleared no-op into execute whenever `bubble` is high. The bench keeps to this by driving every input from its own behavioural pipeline. That pipeline shifts on each clock, holds decode and injects a no-op whenever its own expected stall is high, and changes the inputs only at the falling edge.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hz_src_pick.sv
module hz_src_pick
  import pipe_hazard_pkg::*;
#(
  parameter int REG_BITS = 5
) (
  input  logic [REG_BITS-1:0] rs,
  input  logic                use_src,
  input  logic [REG_BITS-1:0] ex_rd,
  input  logic                ex_we,
  input  logic [REG_BITS-1:0] mem_rd,
  input  logic                mem_we,
  output fwd_src_e            sel
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  logic hit_near;
  logic hit_far;

  // the nearer producer moves to EX/MEM, the farther one to MEM/WB
  assign hit_near = use_src && ex_we  && (ex_rd  != ZERO_REG) && (ex_rd  == rs);
  assign hit_far  = use_src && mem_we && (mem_rd != ZERO_REG) && (mem_rd == rs);

  always_comb begin
    if (hit_near)     sel = FWD_EXM;
    else if (hit_far) sel = FWD_MWB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int REG_BITS    = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic [REG_BITS-1:0] id_rs1,
  input  logic [REG_BITS-1:0] id_rs2,
  input  logic                id_use1,
  input  logic                id_use2,
  input  logic [REG_BITS-1:0] ex_rd,
  input  logic                ex_we,
  input  logic                ex_load,
  input  logic                mem_acc,
  output logic                load_use,
  output logic                port_busy
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  logic ld_live;
  assign ld_live  = ex_load && ex_we && (ex_rd != ZERO_REG);
  assign load_use = ld_live && ((id_use1 && (id_rs1 == ex_rd)) ||
                                (id_use2 && (id_rs2 == ex_rd)));

  generate
    if (SHARED_PORT) begin : g_shared
      assign port_busy = mem_acc;
    end else begin : g_split
      assign port_busy = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_BITS    = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_BITS-1:0] id_rs1,
  input  logic [REG_BITS-1:0] id_rs2,
  input  logic                id_use1,
  input  logic                id_use2,
  input  logic [REG_BITS-1:0] ex_rd,
  input  logic                ex_we,
  input  logic                ex_load,
  input  logic [REG_BITS-1:0] mem_rd,
  input  logic                mem_we,
  input  logic                mem_acc,
  output logic [1:0]          fwd_a,
  output logic [1:0]          fwd_b,
  output logic                stall,
  output logic                bubble
);
  localparam int N_OPS = 2;

  logic [REG_BITS-1:0] src_rs  [N_OPS];
  logic                src_use [N_OPS];
  fwd_src_e            sel_nxt [N_OPS];
  fwd_src_e            sel_q   [N_OPS];
  logic                load_use;
  logic                port_busy;

  assign src_rs[0]  = id_rs1;
  assign src_rs[1]  = id_rs2;
  assign src_use[0] = id_use1;
  assign src_use[1] = id_use2;

  generate
    for (genvar g = 0; g < N_OPS; g++) begin : g_op
      hz_src_pick #(.REG_BITS(REG_BITS)) u_pick (
        .rs      (src_rs[g]),
        .use_src (src_use[g]),
        .ex_rd   (ex_rd),
        .ex_we   (ex_we),
        .mem_rd  (mem_rd),
        .mem_we  (mem_we),
        .sel     (sel_nxt[g])
      );

      // select travels with the decode-to-execute register; a no-op reads the file
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_q[g] <= FWD_RF;
        else if (stall) sel_q[g] <= FWD_RF;
        else            sel_q[g] <= sel_nxt[g];
      end
    end
  endgenerate

  hz_interlock #(.REG_BITS(REG_BITS), .SHARED_PORT(SHARED_PORT)) u_lock (
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .id_use1   (id_use1),
    .id_use2   (id_use2),
    .ex_rd     (ex_rd),
    .ex_we     (ex_we),
    .ex_load   (ex_load),
    .mem_acc   (mem_acc),
    .load_use  (load_use),
    .port_busy (port_busy)
  );

  assign stall  = load_use || port_busy;
  assign bubble = stall;
  assign fwd_a  = sel_q[0];
  assign fwd_b  = sel_q[1];
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int REG_BITS    = 5,
  parameter bit SHARED_PORT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [REG_BITS-1:0] ex_rd,
  input logic                ex_we,
  input logic [REG_BITS-1:0] mem_rd,
  input logic                mem_acc,
  input logic [1:0]          fwd_a,
  input logic [1:0]          fwd_b,
  input logic                stall,
  input logic                bubble
);
  localparam logic [REG_BITS-1:0] ZERO_REG = '0;

  // R6
  stall_bubble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall == bubble);

  // R6
  noop_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

  // R4
  zero_dest_no_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO_REG || !ex_we) |=> (fwd_a != 2'b10 && fwd_b != 2'b10));

  // R4
  zero_dest_no_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == ZERO_REG) |=> (fwd_a != 2'b01 && fwd_b != 2'b01));

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11 && fwd_b != 2'b11));

  // R7
  port_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SHARED_PORT && mem_acc) |-> stall);
endmodule

bind pipe_hazard_ctl pipe_hazard_chk #(.REG_BITS(REG_BITS), .SHARED_PORT(SHARED_PORT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ex_rd   (ex_rd),
  .ex_we   (ex_we),
  .mem_rd  (mem_rd),
  .mem_acc (mem_acc),
  .fwd_a   (fwd_a),
  .fwd_b   (fwd_b),
  .stall   (stall),
  .bubble  (bubble)
);

// File: tb/pipe_hazard_ctl_bench.sv
module pipe_hazard_ctl_bench;
  typedef struct {
    int rd, rs1, rs2;
    bit u1, u2, we, ld, mem;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic id_use1 = 0, id_use2 = 0, ex_we = 0, ex_load = 0, mem_we = 0, mem_acc = 0;
  logic [1:0] fwd_a, fwd_b, fwd_a2, fwd_b2;
  logic stall, bubble, stall2, bubble2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ins_t prog [64];
  int n_prog = 0;
  ins_t s_id, s_ex, s_mem, s_wb, nop;

  always #10 clk = ~clk;

  pipe_hazard_ctl #(.REG_BITS(5), .SHARED_PORT(1'b1)) u_pipe_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use1(id_use1), .id_use2(id_use2), .ex_rd(ex_rd), .ex_we(ex_we),
    .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we), .mem_acc(mem_acc),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble));

  pipe_hazard_ctl #(.REG_BITS(5), .SHARED_PORT(1'b0)) u_pipe_hazard_ctl_split (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use1(id_use1), .id_use2(id_use2), .ex_rd(ex_rd), .ex_we(ex_we),
    .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we), .mem_acc(mem_acc),
    .fwd_a(fwd_a2), .fwd_b(fwd_b2), .stall(stall2), .bubble(bubble2));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic add(input int rd, input int rs1, input int rs2, input bit u1,
                     input bit u2, input bit we, input bit ld, input bit mem);
    prog[n_prog] = '{rd, rs1, rs2, u1, u2, we, ld, mem};
    n_prog++;
  endtask

  function automatic bit hits(input ins_t p, input int rs, input bit u);
    return u && p.we && p.rd != 0 && p.rd == rs;
  endfunction

  // expected select for an operand of the instruction in execute
  function automatic int exp_sel(input int rs, input bit u);
    if (hits(s_mem, rs, u)) return 2;
    if (hits(s_wb, rs, u))  return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input int rs, input bit u);
    if (hits(s_mem, rs, u) && hits(s_wb, rs, u)) return "R3";
    if (hits(s_mem, rs, u)) return "R1";
    if (hits(s_wb, rs, u) && s_wb.ld) return "R5";
    if (hits(s_wb, rs, u)) return "R2";
    return "R4";
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit lu, sp;
    int pc;
    nop = '{0, 0, 0, 0, 0, 0, 0, 0};
    s_id = nop; s_ex = nop; s_mem = nop; s_wb = nop;
    // rd, rs1, rs2, u1, u2, we, ld, mem
    add(1, 2, 3, 1, 1, 1, 0, 0);
    add(4, 1, 1, 1, 1, 1, 0, 0);    // R1 on both operands
    add(5, 1, 6, 1, 1, 1, 0, 0);    // R2 distance two
    add(7, 8, 9, 1, 1, 1, 0, 0);
    add(7, 8, 9, 1, 1, 1, 0, 0);
    add(10, 7, 7, 1, 1, 1, 0, 0);   // R3 both stages write r7
    add(0, 2, 3, 1, 1, 1, 0, 0);
    add(11, 0, 0, 1, 1, 1, 0, 0);   // R4 destination r0
    add(12, 2, 0, 1, 0, 1, 1, 1);   // load r12
    add(13, 12, 12, 1, 1, 1, 0, 0); // R5 load-use
    add(14, 2, 0, 1, 0, 1, 1, 1);   // load r14
    add(15, 3, 14, 1, 0, 1, 0, 0);  // R4 unused operand matches
    add(16, 14, 14, 1, 1, 1, 0, 0); // distance two after load
    add(20, 1, 4, 1, 1, 0, 0, 1);   // store, write-enable low
    add(21, 20, 20, 1, 1, 1, 0, 0); // R4 no bypass from store
    add(22, 21, 3, 1, 1, 1, 0, 0);
    add(23, 22, 21, 1, 1, 1, 0, 0);

    repeat (2) @(negedge clk);
    // R8 reset state
    chk("R8", fwd_a, 0);
    chk("R8", fwd_b, 0);
    rst_n = 1'b1;
    pc = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      id_rs1 = 5'(s_id.rs1); id_rs2 = 5'(s_id.rs2);
      id_use1 = s_id.u1; id_use2 = s_id.u2;
      ex_rd = 5'(s_ex.rd); ex_we = s_ex.we; ex_load = s_ex.ld;
      mem_rd = 5'(s_mem.rd); mem_we = s_mem.we; mem_acc = s_mem.mem;
      #5;
      lu = s_ex.ld && hits(s_ex, s_id.rs1, s_id.u1) || s_ex.ld && hits(s_ex, s_id.rs2, s_id.u2);
      sp = s_mem.mem;
      chk(lu ? "R5" : (sp ? "R7" : "R6"), stall, lu || sp);
      chk("R6", bubble, stall);
      chk("R7", stall2, lu);
      chk(sel_tag(s_ex.rs1, s_ex.u1), fwd_a, exp_sel(s_ex.rs1, s_ex.u1));
      chk(sel_tag(s_ex.rs2, s_ex.u2), fwd_b, exp_sel(s_ex.rs2, s_ex.u2));
      @(posedge clk);
      #1;
      s_wb = s_mem;
      s_mem = s_ex;
      if (lu || sp) begin
        s_ex = nop;
      end else begin
        s_ex = s_id;
        if (pc < n_prog) begin
          s_id = prog[pc];
          pc++;
        end else begin
          s_id = nop;
        end
      end
      if (pc >= n_prog && s_id == nop && s_ex == nop && s_mem == nop && s_wb == nop) break;
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule